// File: doc/BRIEF.md
# Rate-Limited Memory Target

This block is a memory target that serves read and write requests from a small internal word array while holding its short-term data rate under a cap. Every accepted read or write occupies a single shared data path for a window whose length is the request's byte count times a cycles-per-byte parameter. Reads and writes draw on the same budget, so either kind blocks the other.

A requester presents a request for one cycle. In that same cycle it gets a combinational accept or reject. A request that arrives while the window is open is rejected, and the target remembers that it owes that requester a retry. Until the retry is paid, every further request is also rejected. When the window closes, the target raises a one-cycle retry pulse. A request that carries the inhibit flag, because another agent supplies the data, is accepted and dropped.

Responses leave on their own channel a fixed number of cycles after acceptance, in the order the requests were accepted. Each response carries the command, the address and the read data.

Top module: `bwmem_top`

## Requirements
- R1: Reads (cmd 0) and writes (cmd 1) share one busy window. After either kind is accepted with a nonzero duration, any non-inhibited request in the next cycle is rejected, whatever its command.
- R2: An accepted read or write of `n` bytes keeps the target busy for exactly `n*CPB` cycles, starting with the cycle after acceptance. In the cycle right after the window ends, a new request is accepted.
- R3: A read or write whose duration is zero (n = 0 or CPB = 0) opens no window. A request in the very next cycle is accepted.
- R4: A non-inhibited request presented while busy is rejected and records an owed retry. `req_accept` and `req_reject` are never both high, and exactly one of them is high whenever `req_valid` is high.
- R5: While a retry is owed, every non-inhibited request is rejected.
- R6: When a window ends and a retry is owed, the owed flag clears and `retry_pulse` is high for exactly one cycle: the first cycle after the window. At any other time `retry_pulse` stays low.
- R7: Commands 2 and 3 are accepted when the target is free and never open a window. They do not touch storage. Their response carries read data 0.
- R8: An inhibited request is accepted in any state, including busy or owed. It writes nothing, produces no response and opens no window.
- R9: An accepted, non-inhibited request with `req_need_rsp` high produces `rsp_valid` exactly `LAT` cycles after acceptance, with its command, its address, and for a read the stored word. With `req_need_rsp` low, no response is produced.
- R10: A write updates byte lane `k` (bits 8k+7:8k) of the addressed word only when `k < n`. Lanes at or above `n` keep their values.
- R11: After reset the target is not busy, owes no retry, `rsp_valid` and `retry_pulse` are low, and a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 2 | 0 read, 1 write, 2/3 other |
| req_addr | input | ADDR_W | Word address |
| req_bytes | input | CNT_W | Byte count |
| req_wdata | input | DATA_W | Write data |
| req_need_rsp | input | 1 | Request expects a response |
| req_inhibit | input | 1 | Another agent supplies the data; drop the request |
| req_accept | output | 1 | Request taken this cycle |
| req_reject | output | 1 | Request refused this cycle |
| retry_pulse | output | 1 | One-cycle invitation to retry |
| rsp_valid | output | 1 | Response present |
| rsp_cmd | output | 2 | Command of the response |
| rsp_addr | output | ADDR_W | Address of the response |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The bench builds the block with CPB = 2, LAT = 3, a 3-bit byte count and 32-bit words. With these values the full byte-count range 0..7 is short enough to sweep for both reads and writes. That range includes counts above the four lanes, the zero-length case and the longest window of 14 cycles. For each count the bench measures the window length through the rejection and retry pulse, and checks the lane mask by reading the word back. The small latency makes it practical to check the response one cycle early and on time.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;

  localparam logic [1:0] CMD_READ  = 2'd0;
  localparam logic [1:0] CMD_WRITE = 2'd1;

  function automatic bit is_rw(input logic [1:0] cmd);
    return (cmd == CMD_READ) || (cmd == CMD_WRITE);
  endfunction

  // busy window length in cycles
  function automatic int unsigned busy_len(input int unsigned nbytes,
                                           input int unsigned cpb);
    return nbytes * cpb;
  endfunction

  // lane k written when k < nbytes
  function automatic bit lane_on(input int unsigned nbytes, input int unsigned lane);
    return lane < nbytes;
  endfunction

endpackage

// File: rtl/bwmem_throttle.sv
module bwmem_throttle #(
  parameter int CNT_W  = 3,
  parameter int CPB    = 2,
  parameter int BUSY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic             req_inhibit,
  output logic             grant,
  output logic             busy,
  output logic             owed,
  output logic             release_ev,
  output logic             retry_pulse
);
  import bwmem_pkg::*;

  logic [BUSY_W-1:0] cnt_q;
  logic              owed_q;
  logic              retry_q;
  logic [BUSY_W-1:0] dur;
  logic              start_win;
  logic              set_owed;

  assign busy       = (cnt_q != '0);
  assign owed       = owed_q;
  assign release_ev = (cnt_q == BUSY_W'(1));
  assign dur        = BUSY_W'(busy_len(int'(req_bytes), CPB));

  always_comb begin
    grant = 1'b0;
    if (req_valid) begin
      if (req_inhibit)  grant = 1'b1;
      else if (owed_q)  grant = 1'b0;
      else if (busy)    grant = 1'b0;
      else              grant = 1'b1;
    end
  end

  assign set_owed  = req_valid && !grant;
  assign start_win = grant && !req_inhibit && is_rw(req_cmd) && (dur != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      owed_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      if (start_win)  cnt_q <= dur;
      else if (busy)  cnt_q <= cnt_q - BUSY_W'(1);
      if (release_ev) begin
        owed_q  <= 1'b0;
        retry_q <= owed_q || set_owed;
      end else begin
        owed_q  <= owed_q || set_owed;
        retry_q <= 1'b0;
      end
    end
  end

  assign retry_pulse = retry_q;
endmodule

// File: rtl/bwmem_store.sv
module bwmem_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import bwmem_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_we;
    assign lane_we = wr_en && lane_on(int'(nbytes), k);
    always_ff @(posedge clk) begin
      if (lane_we) mem[addr][8*k +: 8] <= wdata[8*k +: 8];
    end
  end
endmodule

// File: rtl/bwmem_rspq.sv
module bwmem_rspq #(
  parameter int W   = 38,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         v_q [LAT];
  logic [W-1:0] d_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= in_valid;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_data;
    for (int i = 1; i < LAT; i++) d_q[i] <= d_q[i-1];
  end

  assign out_valid = v_q[LAT-1];
  assign out_data  = d_q[LAT-1];
endmodule

// File: rtl/bwmem_top.sv
module bwmem_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3,
  parameter int CPB    = 2,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_need_rsp,
  input  logic              req_inhibit,
  output logic              req_accept,
  output logic              req_reject,
  output logic              retry_pulse,
  output logic              rsp_valid,
  output logic [1:0]        rsp_cmd,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_rdata
);
  import bwmem_pkg::*;

  localparam int MAX_BYTES = (1 << CNT_W) - 1;
  localparam int MAX_BUSY  = MAX_BYTES * CPB;
  localparam int BUSY_W    = (MAX_BUSY < 2) ? 1 : $clog2(MAX_BUSY + 1);
  localparam int PAY_W     = 2 + ADDR_W + DATA_W;

  logic              grant;
  logic              busy_w;
  logic              owed_w;
  logic              release_w;
  logic              take;
  logic              do_write;
  logic              do_rsp;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rsp_word;
  logic [PAY_W-1:0]  q_in;
  logic [PAY_W-1:0]  q_out;

  bwmem_throttle #(.CNT_W(CNT_W), .CPB(CPB), .BUSY_W(BUSY_W)) u_thr (
    .clk, .rst_n, .req_valid, .req_cmd, .req_bytes, .req_inhibit,
    .grant, .busy(busy_w), .owed(owed_w), .release_ev(release_w),
    .retry_pulse
  );

  assign req_accept = grant;
  assign req_reject = req_valid && !grant;
  assign take       = grant && !req_inhibit;
  assign do_write   = take && (req_cmd == CMD_WRITE);
  assign do_rsp     = take && req_need_rsp;

  bwmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_mem (
    .clk, .wr_en(do_write), .addr(req_addr), .nbytes(req_bytes),
    .wdata(req_wdata), .rdata(rd_word)
  );

  assign rsp_word = (req_cmd == CMD_READ) ? rd_word : '0;
  assign q_in     = {req_cmd, req_addr, rsp_word};

  bwmem_rspq #(.W(PAY_W), .LAT(LAT)) u_q (
    .clk, .rst_n, .in_valid(do_rsp), .in_data(q_in),
    .out_valid(rsp_valid), .out_data(q_out)
  );

  assign {rsp_cmd, rsp_addr, rsp_rdata} = q_out;
endmodule

// File: rtl/bwmem_chk.sv
module bwmem_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_inhibit,
  input logic req_accept,
  input logic req_reject,
  input logic retry_pulse,
  input logic busy_w,
  input logic owed_w
);
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> (req_accept ^ req_reject)); // R4
  AST_NO_ANSWER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |-> !(req_accept || req_reject)); // R4
  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n) (busy_w && req_valid && !req_inhibit) |-> req_reject); // R4
  AST_OWED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n) (owed_w && req_valid && !req_inhibit) |-> req_reject); // R5
  AST_INHIBIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_inhibit) |-> req_accept); // R8
  AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) retry_pulse |=> !retry_pulse); // R6
  AST_RETRY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n) retry_pulse |-> (!busy_w && !owed_w)); // R6
endmodule

bind bwmem_top bwmem_chk u_chk (
  .clk, .rst_n, .req_valid, .req_inhibit, .req_accept, .req_reject,
  .retry_pulse, .busy_w, .owed_w
);

// File: tb/bwmem_top_tb.sv
module bwmem_top_tb;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 3;
  localparam int CPB    = 2;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0] req_bytes = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_need_rsp = 1'b0;
  logic req_inhibit = 1'b0;
  logic req_accept, req_reject, retry_pulse, rsp_valid;
  logic [1:0] rsp_cmd;
  logic [ADDR_W-1:0] rsp_addr;
  logic [DATA_W-1:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic last_acc;

  always #(CLK_NS/2) clk = ~clk;

  bwmem_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CPB(CPB), .LAT(LAT)) u_dut (
    .clk, .rst_n, .req_valid, .req_cmd, .req_addr, .req_bytes, .req_wdata,
    .req_need_rsp, .req_inhibit, .req_accept, .req_reject, .retry_pulse,
    .rsp_valid, .rsp_cmd, .rsp_addr, .rsp_rdata
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // present one request for one cycle; last_acc holds the answer
  task automatic issue(input logic [1:0] cmd, input int addr, input int nb,
                       input logic [DATA_W-1:0] wd, input logic need, input logic inh);
    req_valid = 1'b1; req_cmd = cmd; req_addr = ADDR_W'(addr);
    req_bytes = CNT_W'(nb); req_wdata = wd; req_need_rsp = need; req_inhibit = inh;
    #1 last_acc = req_accept;
    step(1);
    req_valid = 1'b0; req_inhibit = 1'b0; req_need_rsp = 1'b0;
  endtask

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                              input logic [DATA_W-1:0] wd, input int nb);
    logic [DATA_W-1:0] r = old;
    for (int k = 0; k < DATA_W/8; k++) if (k < nb) r[8*k +: 8] = wd[8*k +: 8];
    return r;
  endfunction

  task automatic read_back(input int addr, input logic [DATA_W-1:0] exp, input string req);
    issue(2'd0, addr, 0, '0, 1'b1, 1'b0);
    check({req, " read accepted"}, last_acc, 1);
    step(LAT - 2);
    check({req, " rsp not early"}, rsp_valid, 0);
    step(1);
    check({req, " rsp valid"}, rsp_valid, 1);
    check({req, " rsp data"}, rsp_rdata, exp);
    check({req, " rsp addr"}, rsp_addr, addr);
    step(1);
  endtask

  initial begin : watchdog
    #(CLK_NS * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [DATA_W-1:0] shadow;
    step(3);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 retry", retry_pulse, 0);
    req_valid = 1'b1; req_cmd = 2'd2; #1;
    check("R11 accept idle", req_accept, 1);
    req_valid = 1'b0;
    step(1);

    // R10 lane mask sweep over every byte count, plus R2 readiness
    for (int nb = 0; nb < 8; nb++) begin
      issue(2'd1, 3, 4, 32'h0, 1'b0, 1'b0);
      step(4 * CPB);
      issue(2'd1, 3, nb, 32'hA1B2C3D4, 1'b0, 1'b0);
      step(nb * CPB);
      // R2: accepted exactly when the window ends
      read_back(3, merge('0, 32'hA1B2C3D4, nb), "R10");
      step(CPB * 0);
      step(0);
      // drain the read's 0-byte window: none
    end

    // R2/R1/R6 window-length sweep: read and write openers, opposite-kind probes
    for (int kind = 0; kind < 2; kind++) begin
      for (int nb = 0; nb < 8; nb++) begin
        int k;
        issue(2'(kind), 6, nb, 32'h5, 1'b0, 1'b0);
        issue(2'(1 - kind), 6, 1, 32'h5, 1'b0, 1'b0);
        if (nb == 0) begin
          check("R3 zero window next accepted", last_acc, 1);
          step(CPB);
        end else begin
          check("R1 shared window rejects", last_acc, 0);
          k = 1;
          while (!retry_pulse && k < 40) begin step(1); k++; end
          check("R2 window length", k, nb * CPB);
          check("R6 retry high", retry_pulse, 1);
          step(1);
          check("R6 retry one cycle", retry_pulse, 0);
        end
      end
    end

    // R5: owed retry keeps rejecting across several requests while busy
    issue(2'd0, 1, 4, '0, 1'b0, 1'b0);
    issue(2'd2, 1, 0, '0, 1'b0, 1'b0);
    check("R5 first reject", last_acc, 0);
    issue(2'd2, 1, 0, '0, 1'b0, 1'b0);
    check("R5 still rejected", last_acc, 0);
    // R8: inhibited write while busy/owed is taken, writes nothing
    shadow = 32'h0;
    issue(2'd1, 3, 4, 32'hDEADBEEF, 1'b1, 1'b1);
    check("R8 inhibit accepted while busy", last_acc, 1);
    for (int i = 0; i < LAT + 1; i++) begin
      check("R8 no response", rsp_valid, 0);
      if (retry_pulse) break;
      step(1);
    end
    while (!retry_pulse) step(1);
    step(1);
    read_back(3, merge('0, 32'hA1B2C3D4, 7), "R8 storage untouched");

    // R7: other command, no window, zero data
    issue(2'd3, 9, 7, 32'hFFFF, 1'b1, 1'b0);
    check("R7 accepted", last_acc, 1);
    issue(2'd2, 9, 7, 32'hFFFF, 1'b0, 1'b0);
    check("R7 no window", last_acc, 1);
    step(LAT - 2);
    check("R7 rsp valid", rsp_valid, 1);
    check("R7 rsp cmd", rsp_cmd, 3);
    check("R7 rsp data zero", rsp_rdata, 0);
    step(1);
    check("R9 no rsp when not needed", rsp_valid, 0);

    // R9: back-to-back zero-length reads keep order
    issue(2'd0, 3, 0, '0, 1'b1, 1'b0);
    issue(2'd0, 5, 0, '0, 1'b1, 1'b0);
    step(LAT - 2);
    check("R9 first addr", rsp_addr, 3);
    check("R9 first cmd", rsp_cmd, 0);
    step(1);
    check("R9 second addr", rsp_addr, 5);
    check("R9 second valid", rsp_valid, 1);
    step(2);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule